// File: doc/BRIEF.md
# Move, OR and Halfword Multiply Execute Unit

This block decodes and executes a small group of integer operations for a 32-bit RISC pipeline. It covers register and immediate moves, add-immediate and high-half moves, bitwise NOT, OR and OR-immediate, and signed halfword multiplies. The multiplies take a register, a 5-bit immediate or a 16-bit immediate as the second operand. The surrounding pipeline supplies the first instruction halfword, the second halfword when the encoding has one, and the values of the two registers the instruction names. The unit returns a registered result bundle: a valid strobe, a write enable, the destination index, the 32-bit data, and a flag-update strobe with new sign, zero and overflow values.

Single-cycle operations present their result one clock after issue. Multiplies present theirs two clocks after issue. During the middle cycle of a multiply the unit raises `busy`, and any instruction offered in that cycle is dropped. A combinational length signal tells the fetch stage when the current encoding occupies two halfwords.

Top module: `movor_mul_unit`

## Requirements
- R1: The first halfword is split as destination/second-source index in bits 15:11, a 6-bit opcode in bits 10:5 and a first-source index or imm5 in bits 4:0. The result index `res_idx` always equals bits 15:11 of the issued halfword.
- R2: Opcode 000000 copies `src_a` to the result. Opcode 010000 writes imm5 sign-extended to 32 bits. Both appear one clock after issue.
- R3: Opcode 110001 writes `src_a` plus the sign-extended second halfword. Opcode 110010 writes `src_a` plus the second halfword placed in bits 31:16 with zeros below.
- R4: Opcode 001000 writes `src_b OR src_a`. Opcode 110100 writes `src_b` ORed with the zero-extended second halfword. Opcode 000001 writes the bitwise inverse of `src_a`.
- R5: The three logical operations raise `flag_we`, with `flag_ov`=0, `flag_s`=result bit 31 and `flag_z`=1 when the result is zero. Moves and multiplies keep `flag_we` low.
- R6: Opcode 000111 multiplies `src_b[15:0]` by `src_a[15:0]`. Opcode 010111 multiplies `src_b[15:0]` by the sign-extended imm5. Opcode 110111 multiplies `src_a[15:0]` by the second halfword. All three multiplies are signed 16x16 and return the full 32-bit product.
- R7: A multiply result appears two clocks after issue. In the clock between, `busy`=1 and `res_valid`=0, and an instruction offered while `busy`=1 produces no result.
- R8: The all-zero halfword is a no-op: `res_valid`=1 one clock later, with `res_wr`=0 and `flag_we`=0.
- R9: A result aimed at register 0 is delivered with `res_wr`=0.
- R10: `is_long`=1 combinationally exactly when `in_valid`=1 and the opcode is 110001, 110010, 110100 or 110111.
- R11: An opcode outside the ten listed ones gives `res_valid`=0 on the following clock.
- R12: While reset is asserted and on the first clock after it, `res_valid`, `res_wr`, `flag_we` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction offered this cycle |
| insn_hw0 | input | 16 | First instruction halfword |
| insn_hw1 | input | 16 | Second halfword (imm16) |
| src_a | input | 32 | Value of the register in bits 4:0 |
| src_b | input | 32 | Value of the register in bits 15:11 |
| is_long | output | 1 | Encoding uses two halfwords |
| busy | output | 1 | Multiply in flight; input ignored |
| res_valid | output | 1 | Result bundle valid |
| res_wr | output | 1 | Register write enable |
| res_idx | output | 5 | Destination register index |
| res_data | output | 32 | Result value |
| flag_we | output | 1 | Flags updated this cycle |
| flag_s | output | 1 | New sign flag |
| flag_z | output | 1 | New zero flag |
| flag_ov | output | 1 | New overflow flag |

## Verification
The hardest case to reach from the ports is an instruction offered in the one cycle while a multiply is still in flight. That case arises only when issue lines up exactly with the multiply's second stage. The multiply scenarios therefore drive a register move with a distinctive value on the clock right after every multiply issue. They then confirm that the product arrives alone, and that no extra result follows on the next clock. Negative halfwords with nonzero upper bits exercise the signed, lower-half-only operand selection.

// File: rtl/movor_pkg.sv
package movor_pkg;
  localparam int XLEN = 32;
  localparam int HW   = 16;
  localparam int RIDX = 5;
  localparam int OPW  = 6;
  localparam int IMM5 = 5;

  localparam logic [OPW-1:0] OPC_MOVR  = 6'b000000;
  localparam logic [OPW-1:0] OPC_NOT   = 6'b000001;
  localparam logic [OPW-1:0] OPC_MULR  = 6'b000111;
  localparam logic [OPW-1:0] OPC_OR    = 6'b001000;
  localparam logic [OPW-1:0] OPC_MOVI  = 6'b010000;
  localparam logic [OPW-1:0] OPC_MULI5 = 6'b010111;
  localparam logic [OPW-1:0] OPC_MOVEA = 6'b110001;
  localparam logic [OPW-1:0] OPC_MOVHI = 6'b110010;
  localparam logic [OPW-1:0] OPC_ORI   = 6'b110100;
  localparam logic [OPW-1:0] OPC_MULI  = 6'b110111;

  typedef enum logic [3:0] {
    K_NONE, K_NOP, K_MOVR, K_MOVI, K_NOT, K_OR, K_MOVEA,
    K_MOVHI, K_ORI, K_MULR, K_MULI5, K_MULI16
  } kind_e;

  function automatic logic [XLEN-1:0] sx5(input logic [IMM5-1:0] v);
    return {{(XLEN-IMM5){v[IMM5-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] sx16(input logic [HW-1:0] v);
    return {{(XLEN-HW){v[HW-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] smul16(input logic [HW-1:0] a,
                                             input logic [HW-1:0] b);
    logic signed [XLEN-1:0] pa, pb;
    pa = signed'(sx16(a));
    pb = signed'(sx16(b));
    return XLEN'(pa * pb);
  endfunction

  function automatic logic is_mul(input kind_e k);
    return (k == K_MULR) || (k == K_MULI5) || (k == K_MULI16);
  endfunction
endpackage

// File: rtl/movor_decode.sv
module movor_decode
  import movor_pkg::*;
(
  input  logic [HW-1:0]   hw0,
  output kind_e           kind,
  output logic [RIDX-1:0] dst,
  output logic [RIDX-1:0] fld_a,
  output logic            long_enc
);
  logic [OPW-1:0] opc;
  assign opc   = hw0[10:5];
  assign dst   = hw0[15:11];
  assign fld_a = hw0[4:0];

  always_comb begin
    kind = K_NONE;
    if (hw0 == '0) kind = K_NOP;
    else begin
      unique case (opc)
        OPC_MOVR:  kind = K_MOVR;
        OPC_NOT:   kind = K_NOT;
        OPC_MULR:  kind = K_MULR;
        OPC_OR:    kind = K_OR;
        OPC_MOVI:  kind = K_MOVI;
        OPC_MULI5: kind = K_MULI5;
        OPC_MOVEA: kind = K_MOVEA;
        OPC_MOVHI: kind = K_MOVHI;
        OPC_ORI:   kind = K_ORI;
        OPC_MULI:  kind = K_MULI16;
        default:   kind = K_NONE;
      endcase
    end
  end

  assign long_enc = (kind == K_MOVEA) || (kind == K_MOVHI) ||
                    (kind == K_ORI)   || (kind == K_MULI16);
endmodule

// File: rtl/movor_alu.sv
module movor_alu
  import movor_pkg::*;
(
  input  kind_e           kind,
  input  logic [RIDX-1:0] fld_a,
  input  logic [HW-1:0]   imm16,
  input  logic [XLEN-1:0] va,
  input  logic [XLEN-1:0] vb,
  output logic [XLEN-1:0] result,
  output logic            logic_op
);
  always_comb begin
    result   = '0;
    logic_op = 1'b0;
    case (kind)
      K_MOVR:  result = va;
      K_MOVI:  result = sx5(fld_a);
      K_MOVEA: result = va + sx16(imm16);
      K_MOVHI: result = va + {imm16, {(XLEN-HW){1'b0}}};
      K_NOT:   begin result = ~va;                              logic_op = 1'b1; end
      K_OR:    begin result = vb | va;                          logic_op = 1'b1; end
      K_ORI:   begin result = vb | {{(XLEN-HW){1'b0}}, imm16};  logic_op = 1'b1; end
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/movor_mul.sv
module movor_mul
  import movor_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  kind_e           kind,
  input  logic [RIDX-1:0] fld_a,
  input  logic [HW-1:0]   imm16,
  input  logic [XLEN-1:0] va,
  input  logic [XLEN-1:0] vb,
  input  logic [RIDX-1:0] dst_in,
  output logic            pend,
  output logic [RIDX-1:0] dst_q,
  output logic [XLEN-1:0] product
);
  logic [HW-1:0] opx, opy, x_q, y_q;

  always_comb begin
    opx = vb[HW-1:0];
    opy = va[HW-1:0];
    case (kind)
      K_MULI5:  opy = sx5(fld_a)[HW-1:0];
      K_MULI16: begin opx = va[HW-1:0]; opy = imm16; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      x_q   <= '0;
      y_q   <= '0;
      dst_q <= '0;
    end else begin
      pend <= start;
      if (start) begin
        x_q   <= opx;
        y_q   <= opy;
        dst_q <= dst_in;
      end
    end
  end

  assign product = smul16(x_q, y_q);
endmodule

// File: rtl/movor_mul_unit.sv
module movor_mul_unit
  import movor_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [15:0]     insn_hw0,
  input  logic [15:0]     insn_hw1,
  input  logic [31:0]     src_a,
  input  logic [31:0]     src_b,
  output logic            is_long,
  output logic            busy,
  output logic            res_valid,
  output logic            res_wr,
  output logic [4:0]      res_idx,
  output logic [31:0]     res_data,
  output logic            flag_we,
  output logic            flag_s,
  output logic            flag_z,
  output logic            flag_ov
);
  kind_e           kind;
  logic [RIDX-1:0] dst, fld_a;
  logic            long_enc, logic_op, pend;
  logic [XLEN-1:0] alu_res, product;
  logic [RIDX-1:0] mul_dst;
  logic            issue, mul_fire, single_fire;

  movor_decode u_dec (.hw0(insn_hw0), .kind(kind), .dst(dst),
                      .fld_a(fld_a), .long_enc(long_enc));

  movor_alu u_alu (.kind(kind), .fld_a(fld_a), .imm16(insn_hw1),
                   .va(src_a), .vb(src_b), .result(alu_res),
                   .logic_op(logic_op));

  assign issue       = in_valid && !pend;
  assign mul_fire    = issue && is_mul(kind);
  assign single_fire = issue && !is_mul(kind) && (kind != K_NONE);

  movor_mul u_mul (.clk(clk), .rst_n(rst_n), .start(mul_fire), .kind(kind),
                   .fld_a(fld_a), .imm16(insn_hw1), .va(src_a), .vb(src_b),
                   .dst_in(dst), .pend(pend), .dst_q(mul_dst),
                   .product(product));

  assign is_long = in_valid && long_enc;
  assign busy    = pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_wr    <= 1'b0;
      res_idx   <= '0;
      res_data  <= '0;
      flag_we   <= 1'b0;
      flag_s    <= 1'b0;
      flag_z    <= 1'b0;
      flag_ov   <= 1'b0;
    end else if (pend) begin
      res_valid <= 1'b1;
      res_wr    <= (mul_dst != '0);
      res_idx   <= mul_dst;
      res_data  <= product;
      flag_we   <= 1'b0;
    end else if (single_fire) begin
      res_valid <= 1'b1;
      res_wr    <= (kind != K_NOP) && (dst != '0);
      res_idx   <= dst;
      res_data  <= alu_res;
      flag_we   <= logic_op;
      if (logic_op) begin
        flag_s  <= alu_res[XLEN-1];
        flag_z  <= (alu_res == '0);
        flag_ov <= 1'b0;
      end
    end else begin
      res_valid <= 1'b0;
      res_wr    <= 1'b0;
      flag_we   <= 1'b0;
      if (in_valid) res_idx <= dst;
    end
  end
endmodule

// File: rtl/movor_unit_chk.sv
module movor_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        busy,
  input logic        mul_fire,
  input logic        res_valid,
  input logic        res_wr,
  input logic [4:0]  res_idx,
  input logic [31:0] res_data,
  input logic        flag_we,
  input logic        flag_s,
  input logic        flag_z,
  input logic        flag_ov
);
  AST_WR_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr |-> res_valid);                                         // R9
  AST_NO_R0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr |-> (res_idx != 5'd0));                                 // R9
  AST_LOGIC_OV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> !flag_ov);                                         // R5
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (flag_z == (res_data == 32'd0)));                  // R5
  AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (flag_s == res_data[31]));                         // R5
  AST_MUL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    mul_fire |=> (busy && !res_valid));                            // R7
  AST_MUL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (res_valid && !busy && !flag_we));                    // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !busy) |=> !res_valid);                          // R12
endmodule

bind movor_mul_unit movor_unit_chk u_chk (.*);

// File: tb/sim_movor_mul_unit.sv
module sim_movor_mul_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] insn_hw0 = '0, insn_hw1 = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic        is_long, busy, res_valid, res_wr, flag_we, flag_s, flag_z, flag_ov;
  logic [4:0]  res_idx;
  logic [31:0] res_data;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  movor_mul_unit u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input logic [4:0] rd, input logic [5:0] op,
                                      input logic [4:0] ra);
    return {rd, op, ra};
  endfunction

  function automatic logic [31:0] mul_ref(input logic [15:0] x, input logic [15:0] y);
    int sx, sy;
    sx = (x[15]) ? int'(x) - 65536 : int'(x);
    sy = (y[15]) ? int'(y) - 65536 : int'(y);
    return 32'(sx * sy);
  endfunction

  // single-cycle op: issue, then check at the next negedge
  task automatic run1(input string req, input logic [15:0] h0, input logic [15:0] h1,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic exp_long, input logic exp_wr, input logic [31:0] exp_d,
                      input logic exp_fwe);
    @(negedge clk);
    in_valid = 1; insn_hw0 = h0; insn_hw1 = h1; src_a = a; src_b = b;
    #0.5 chk({req, " R10 is_long"}, is_long, exp_long);
    @(negedge clk);
    in_valid = 0;
    chk({req, " valid"}, res_valid, 1);
    chk({req, " R1 idx"}, res_idx, h0[15:11]);
    chk({req, " wr"}, res_wr, exp_wr);
    if (h0 != 0) chk({req, " data"}, res_data, exp_d);
    chk({req, " R5 flag_we"}, flag_we, exp_fwe);
    if (exp_fwe) begin
      chk({req, " R5 ov"}, flag_ov, 0);
      chk({req, " R5 s"}, flag_s, exp_d[31]);
      chk({req, " R5 z"}, flag_z, exp_d == 0);
    end
  endtask

  // multiply: offer a move during busy, which must be dropped (R7)
  task automatic run_mul(input string req, input logic [15:0] h0, input logic [15:0] h1,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] exp_d);
    @(negedge clk);
    in_valid = 1; insn_hw0 = h0; insn_hw1 = h1; src_a = a; src_b = b;
    @(negedge clk);
    chk({req, " R7 busy"}, busy, 1);
    chk({req, " R7 no early valid"}, res_valid, 0);
    insn_hw0 = enc(5'd5, 6'b000000, 5'd1); src_a = 32'hDEAD_BEEF;
    @(negedge clk);
    in_valid = 0;
    chk({req, " R7 valid"}, res_valid, 1);
    chk({req, " R6 data"}, res_data, exp_d);
    chk({req, " R1 idx"}, res_idx, h0[15:11]);
    chk({req, " R5 no flags"}, flag_we, 0);
    chk({req, " R7 not busy"}, busy, 0);
    @(negedge clk);
    chk({req, " R7 dropped op"}, res_valid, 0);
  endtask

  task automatic t_reset;
    #1 chk("R12 valid in reset", res_valid, 0);
    chk("R12 busy in reset", busy, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R12 valid after", res_valid, 0);
    chk("R12 wr after", res_wr, 0);
    chk("R12 flag_we after", flag_we, 0);
  endtask

  task automatic t_moves;
    run1("R2 movr", enc(3, 6'b000000, 7), 0, 32'h1234_5678, 0, 0, 1, 32'h1234_5678, 0);
    run1("R2 movi", enc(4, 6'b010000, 5'b10110), 0, 0, 0, 0, 1, 32'hFFFF_FFF6, 0);
    run1("R3 movea", enc(6, 6'b110001, 2), 16'h8000, 32'h0001_0000, 0, 1, 1, 32'h0000_8000, 0);
    run1("R3 movhi", enc(7, 6'b110010, 2), 16'hABCD, 32'h0000_1111, 0, 1, 1, 32'hABCD_1111, 0);
  endtask

  task automatic t_logic;
    run1("R4 or", enc(8, 6'b001000, 9), 0, 32'h8000_00F0, 32'h0000_0F00, 0, 1, 32'h8000_0FF0, 1);
    run1("R4 ori", enc(8, 6'b110100, 9), 16'h8001, 32'hFFFF_FFFF, 32'h0000_0000, 1, 1, 32'h0000_8001, 1);
    run1("R4 not zero", enc(10, 6'b000001, 1), 0, 32'hFFFF_FFFF, 0, 0, 1, 32'h0, 1);
    run1("R4 not neg", enc(10, 6'b000001, 1), 0, 32'h0000_0001, 0, 0, 1, 32'hFFFF_FFFE, 1);
  endtask

  task automatic t_mul;
    run_mul("R6 mulr", enc(11, 6'b000111, 12), 0, 32'h7777_FFFE, 32'h5555_0003,
            mul_ref(16'h0003, 16'hFFFE));
    run_mul("R6 muli5", enc(12, 6'b010111, 5'b10000), 0, 0, 32'h0000_8000,
            mul_ref(16'h8000, 16'hFFF0));
    run_mul("R6 muli16", enc(13, 6'b110111, 1), 16'h7FFF, 32'hAAAA_8001, 32'h0,
            mul_ref(16'h8001, 16'h7FFF));
  endtask

  task automatic t_special;
    run1("R8 nop", 16'h0000, 0, 32'h5, 32'h6, 0, 0, 0, 0);
    run1("R9 r0 dest", enc(0, 6'b010000, 5'd3), 0, 0, 0, 0, 0, 32'd3, 0);
    @(negedge clk);
    in_valid = 1; insn_hw0 = enc(2, 6'b111111, 1);
    #0.5 chk("R10 unknown not long", is_long, 0);
    @(negedge clk);
    in_valid = 0;
    chk("R11 unknown op", res_valid, 0);
  endtask

  initial begin
    t_reset();
    t_moves();
    t_logic();
    t_mul();
    t_special();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule